// File: doc/BRIEF.md
# Watchdog Tick Prescaler with Deferred Ratio Switch

This block sits in front of a watchdog down-counter and turns the free-running kernel clock into a one-cycle tick enable. The tick repeats once per division period, and the period is a power of two that a 4-bit ratio code selects. The counter it drives steps only when the tick is high, so every edge stays in the kernel clock domain and no derived clock is created.

Software or a register shadow asks for a new ratio by pulsing an update strobe with the code alongside. The block captures the code, raises a busy flag, and lets the period already running finish at its old length. At the end of that period the new ratio takes over, the internal count starts again from zero, and the busy flag drops. Because of this, no tick ever arrives early or late while the ratio changes. A strobe that arrives while an earlier change is still pending is dropped.

Top module: `wdt_tick_prescaler`

## Requirements
- R1: Ratio codes 0 to 7 give a period of 4, 8, 16, 32, 64, 128, 256 and 512 kernel cycles. Each code doubles the one below it.
- R2: Every ratio code from 8 to 15 gives a period of 1024 kernel cycles.
- R3: After reset the code is 0. The period is 4, `busy_o` and `tick_o` are low, and the first tick is high in the fourth cycle after reset is released.
- R4: `tick_o` is high for exactly one kernel cycle, which is the last cycle of each period. With the ratio held steady, consecutive ticks are exactly one period apart.
- R5: If `update_req_i` is sampled high while `busy_o` is low, the code on `ratio_code_i` is captured and `busy_o` is high from the next cycle on.
- R6: A captured ratio does not shorten or stretch the period that is running when it is captured. That period ends at its old length.
- R7: At the clock edge that ends the period in progress, the captured ratio becomes active and `busy_o` goes low in the same cycle. The next tick comes exactly one full new period later, counted from zero.
- R8: If `update_req_i` is sampled high while `busy_o` is high, the request is ignored. The ratio that becomes active is the one captured first.
- R9: If a request is accepted in the same cycle that `tick_o` is high, the period boundary at that edge does not apply it. One more full period of the old ratio runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_code_i | input | 4 | Requested ratio code, sampled with the update strobe |
| update_req_i | input | 1 | Update strobe; captures `ratio_code_i` when not busy |
| tick_o | output | 1 | One-cycle enable on the last cycle of each period |
| busy_o | output | 1 | High while a captured ratio waits for the period boundary |

## Verification
The assertions assume that `update_req_i` and `ratio_code_i` change only in step with the kernel clock. They make no assumption about how often the strobe arrives, so requests made while busy are legal stimulus. The bench drives every input on the falling edge and reads back at the falling edge, so each input is settled well before a rising edge samples it. It steps through all sixteen codes in turn and times each old and new period arithmetically from the code. It also sends strobes in the two sensitive spots: one while busy and one in the tick cycle itself.

// File: rtl/wdt_presc_pkg.sv
package wdt_presc_pkg;

    // Map a ratio code to the log2 of the division period, saturating at max_exp.
    function automatic int code_to_exp(input int code, input int base_exp, input int max_exp);
        int e;
        if (code >= (max_exp - base_exp)) begin
            e = max_exp;
        end else begin
            e = base_exp + code;
        end
        return e;
    endfunction

endpackage

// File: rtl/wdt_presc_update.sv
module wdt_presc_update #(
    parameter int CODE_W   = 4,
    parameter int BASE_EXP = 2,
    parameter int MAX_EXP  = 10,
    localparam int EXP_W   = $clog2(MAX_EXP + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    input  logic              req_i,
    input  logic              period_end_i,
    output logic              busy_o,
    output logic              apply_o,
    output logic [EXP_W-1:0]  new_exp_o
);
    import wdt_presc_pkg::*;

    typedef struct packed {
        logic             busy;
        logic [EXP_W-1:0] pend_exp;
    } upd_state_t;

    upd_state_t st_d, st_q;
    logic       accept;
    logic       apply;

    always_comb begin
        st_d   = st_q;
        accept = req_i && !st_q.busy;
        apply  = st_q.busy && period_end_i;
        if (accept) begin
            st_d.busy     = 1'b1;
            st_d.pend_exp = EXP_W'(code_to_exp(int'(code_i), BASE_EXP, MAX_EXP));
        end else if (apply) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.busy     <= 1'b0;
            st_q.pend_exp <= EXP_W'(BASE_EXP);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign apply_o   = apply;
    assign new_exp_o = st_q.pend_exp;

    // R5: an accepted strobe raises the busy flag on the next cycle
    a_r5_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !busy_o) |=> busy_o);

    // R8: while busy and no boundary, the captured value and flag hold
    a_r8_pending_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !period_end_i) |=> (busy_o && $stable(new_exp_o)));

    // R7: the period boundary while busy drops the flag
    a_r7_busy_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && period_end_i) |=> !busy_o);

endmodule

// File: rtl/wdt_presc_divider.sv
module wdt_presc_divider #(
    parameter int BASE_EXP = 2,
    parameter int MAX_EXP  = 10,
    localparam int EXP_W   = $clog2(MAX_EXP + 1),
    localparam int CNT_W   = MAX_EXP
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             apply_i,
    input  logic [EXP_W-1:0] new_exp_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t     st_d, st_q;
    logic [CNT_W:0] span;
    logic [CNT_W-1:0] last;
    logic           at_last;

    always_comb begin
        span    = (CNT_W+1)'(1) << st_q.exp;
        last    = CNT_W'(span - (CNT_W+1)'(1));
        at_last = (st_q.cnt == last);
        st_d    = st_q;
        if (at_last) begin
            st_d.cnt = '0;
            if (apply_i) begin
                st_d.exp = new_exp_i;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.exp <= EXP_W'(BASE_EXP);
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = at_last;

    // R4: a tick is never followed by another tick (minimum period is four)
    a_r4_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

    // R4: the count restarts from zero after every tick
    a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (st_q.cnt == '0));

    // R6: the active ratio changes only at a boundary with an apply request
    a_r6_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(apply_i && tick_o) |=> $stable(st_q.exp));

    // R1: the active exponent stays inside the legal range
    a_r1_exp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.exp >= EXP_W'(BASE_EXP)) && (st_q.exp <= EXP_W'(MAX_EXP)));

endmodule

// File: rtl/wdt_tick_prescaler.sv
module wdt_tick_prescaler #(
    parameter int CODE_W   = 4,
    parameter int BASE_EXP = 2,
    parameter int MAX_EXP  = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] ratio_code_i,
    input  logic              update_req_i,
    output logic              tick_o,
    output logic              busy_o
);
    localparam int EXP_W = $clog2(MAX_EXP + 1);

    logic             tick;
    logic             apply;
    logic [EXP_W-1:0] new_exp;

    wdt_presc_update #(
        .CODE_W  (CODE_W),
        .BASE_EXP(BASE_EXP),
        .MAX_EXP (MAX_EXP)
    ) u_update (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .code_i      (ratio_code_i),
        .req_i       (update_req_i),
        .period_end_i(tick),
        .busy_o      (busy_o),
        .apply_o     (apply),
        .new_exp_o   (new_exp)
    );

    wdt_presc_divider #(
        .BASE_EXP(BASE_EXP),
        .MAX_EXP (MAX_EXP)
    ) u_divider (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .apply_i  (apply),
        .new_exp_i(new_exp),
        .tick_o   (tick)
    );

    assign tick_o = tick;

    // R7: busy is never high right after a tick that it was waiting on
    a_r7_switch_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && tick_o && !update_req_i) |=> !busy_o);

endmodule

// File: tb/wdt_tick_prescaler_test.sv
module wdt_tick_prescaler_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code = 4'd0;
    logic       req = 1'b0;
    logic       tick;
    logic       busy;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    wdt_tick_prescaler uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ratio_code_i(code),
        .update_req_i(req),
        .tick_o      (tick),
        .busy_o      (busy)
    );

    function automatic int ratio_of(input int c);
        return (c >= 8) ? 1024 : (4 << c);
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Falling edges until tick is seen high; returns how many were stepped.
    task automatic to_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 5000);
    endtask

    // Switch ratio from old_c to new_c with a strobe at the start of a period.
    task automatic switch_ratio(input int old_c, input int new_c, input bit poke_busy);
        int n;
        to_tick(n);
        @(negedge clk);
        code = 4'(new_c);
        req  = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R5 busy after request", int'(busy), 1);
        if (poke_busy) begin
            code = 4'(new_c ^ 1);
            req  = 1'b1;
            @(negedge clk);
            req = 1'b0;
            to_tick(n);
            n += 2;
        end else begin
            to_tick(n);
            n += 1;
        end
        check(n == ratio_of(old_c) - 1, "R6 old period kept", n, ratio_of(old_c) - 1);
        check(busy == 1'b1, "R5 busy held to boundary", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b0, "R7 busy clear at switch", int'(busy), 0);
        check(tick == 1'b0, "R4 tick one cycle wide", int'(tick), 0);
        to_tick(n);
        check(n == ratio_of(new_c) - 1, poke_busy ? "R8 first code wins" : "R7 new period from zero",
              n, ratio_of(new_c) - 1);
        to_tick(n);
        check(n == ratio_of(new_c), new_c >= 8 ? "R2 saturated period" : "R1 period by code",
              n, ratio_of(new_c));
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R3 tick low in reset", int'(tick), 0);
        check(busy == 1'b0, "R3 busy low in reset", int'(busy), 0);
        rst_n = 1'b1;
        to_tick(n);
        check(n == 3, "R3 first tick cycle", n, 3);
        to_tick(n);
        check(n == 4, "R4 default period", n, 4);

        // Sweep every code, each switch starting from the previous one.
        for (int c = 1; c < 16; c++) begin
            switch_ratio(c - 1, c, 1'b0);
        end
        switch_ratio(15, 0, 1'b0);

        // R8: a second strobe while busy is dropped
        switch_ratio(0, 3, 1'b1);
        switch_ratio(3, 6, 1'b1);

        // R9: strobe in the tick cycle waits one more full old period
        to_tick(n);
        code = 4'd2;
        req  = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(busy == 1'b1, "R9 accepted on tick", int'(busy), 1);
        to_tick(n);
        check(n == ratio_of(6) - 1, "R9 old period runs once more", n, ratio_of(6) - 1);
        check(busy == 1'b1, "R9 still busy at boundary", int'(busy), 1);
        @(negedge clk);
        check(busy == 1'b0, "R9 busy clear", int'(busy), 0);
        to_tick(n);
        check(n == ratio_of(2) - 1, "R9 new period", n, ratio_of(2) - 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule